// File: doc/BRIEF.md
# Indirect Register Access Sequencer

This block is the host-side engine for reaching registers that sit behind a command/data register pair on a management bus. A user hands it one request: read or write, a target device number, a register number and, for writes, a 16-bit value. The block then runs the whole access on its own through a single-transaction bus master port. It polls the busy flag in the command register and writes the data register and the command word in the order the operation needs. On a read it fetches the data register at the end. It hands back one response carrying a status code and, for a successful read, the data.

The request and response sides are valid/ready streams. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle, so a requester may hold `req_valid` and its fields for as long as it likes. A response is presented with `rsp_valid` and held, fields unchanged, until the requester raises `rsp_ready`. While `rsp_ready` stays low the sequencer stays stalled and accepts nothing new. The bus port is plain control: `bus_start` pulses for one cycle with address, register, direction and write data valid. The bus answers later with a one-cycle `bus_done` carrying `bus_err` and `bus_rdata`. Only one bus transaction is ever outstanding. `strap_addr` gives the bus address of the pair.

Top module: `ind_reg_seq`

## Requirements
- R1: Out of reset, and whenever no request is being processed and no response is pending, `req_ready` is 1, `rsp_valid` is 0 and `bus_start` is 0. `req_ready` is 0 from the cycle after acceptance until the response is taken. Request inputs seen while `req_ready` is 0 have no effect on the bus traffic or the response.
- R2: A poll is a read of register 0 (the command register). A poll succeeds when bit 15 of the returned word is 0, and the other bits are ignored.
- R3: A single wait phase issues at most 16 polls. If 16 consecutive polls all show bit 15 set, the response has status 1 (timeout) and no further bus transaction is issued.
- R4: A read request issues, in order: poll until not busy, a command write, poll until not busy, then a read of register 1 (the data register). A successful read responds with status 0 and the value of that final read.
- R5: A write request issues, in order: poll until not busy, a write of the request data to register 1, a command write, then poll until not busy. It responds with status 0.
- R6: The command word written to register 0 has bit 15 = 1 (busy) and bit 12 = 1 (format). Bits 11:10 hold the opcode, 10 for read and 01 for write. Bits 9:5 hold the device number and bits 4:0 the register number.
- R7: A transaction that completes with `bus_err` = 1 ends the sequence at once. The response has status 2 (bus error) and no further bus transaction is issued.
- R8: Every accepted request yields exactly one response. Its status and data stay unchanged while `rsp_valid` is high and `rsp_ready` is low.
- R9: `rsp_rdata` is 0 in every response except a successful read.
- R10: A new `bus_start` is never issued before the previous transaction's `bus_done`, and every transaction uses `strap_addr` as its bus address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_addr | input | 5 | Bus address of the command/data pair |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dev | input | 5 | Target device number |
| req_reg | input | 5 | Target register number |
| req_wdata | input | 16 | Data for a write |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_err | output | 2 | 0 none, 1 timeout, 2 bus error |
| rsp_rdata | output | 16 | Read data, 0 unless a successful read |
| bus_start | output | 1 | One-cycle start of a bus transaction |
| bus_addr | output | 5 | Bus address of the transaction |
| bus_reg | output | 5 | Register offset, 0 command, 1 data |
| bus_write | output | 1 | 1 = write transaction |
| bus_wdata | output | 16 | Write data |
| bus_done | input | 1 | Transaction finished |
| bus_err | input | 1 | Transaction failed (valid with bus_done) |
| bus_rdata | input | 16 | Read result (valid with bus_done) |

## Verification
The bench sweeps the busy count seen by each wait phase from zero through seventeen, for both operations, and injects a bus error at every transaction position. It compares the full logged transaction list against an expected list built from the rules above. A poll limit off by one would show as a seventeenth poll or an early timeout. Testing the wrong busy bit would be exposed because non-busy polls return every other bit set. A read or write with the data and command steps swapped, or a sequence that carries on after an error, would break the list order or length. Responses are also held back with `rsp_ready` low to catch data that drifts. Garbage requests are held on the inputs during a sequence to catch a second acceptance.

// File: rtl/ind_reg_seq_pkg.sv
package ind_reg_seq_pkg;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_TIMEOUT = 2'd1,
    ST_BUSERR  = 2'd2
  } seq_status_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_POLL_PRE,
    PH_DATA_WR,
    PH_CMD_WR,
    PH_POLL_POST,
    PH_DATA_RD,
    PH_RESP
  } seq_phase_e;

  // command word fields (16-bit word)
  localparam logic [15:0] CMD_BUSY_FLAG = 16'h8000;
  localparam logic [15:0] CMD_FORMAT    = 16'h1000;
  localparam logic [15:0] CMD_OP_READ   = 16'h0800;
  localparam logic [15:0] CMD_OP_WRITE  = 16'h0400;

endpackage

// File: rtl/ind_reg_cmd_fmt.sv
module ind_reg_cmd_fmt
  import ind_reg_seq_pkg::*;
#(
  parameter int DEV_W  = 5,
  parameter int REG_W  = 5,
  parameter int DATA_W = 16
) (
  input  logic              is_write,
  input  logic [DEV_W-1:0]  dev_num,
  input  logic [REG_W-1:0]  reg_num,
  output logic [DATA_W-1:0] cmd_word
);

  localparam int FIELD_W = DEV_W + REG_W;

  logic [15:0]      fixed_bits;
  logic [FIELD_W-1:0] addr_field;

  always_comb begin
    fixed_bits = CMD_BUSY_FLAG | CMD_FORMAT | (is_write ? CMD_OP_WRITE : CMD_OP_READ);
    addr_field = {dev_num, reg_num};
    cmd_word   = DATA_W'(fixed_bits) | DATA_W'(addr_field);
  end

  initial begin
    a_r6_fields_fit: assert (FIELD_W <= 10 && DATA_W == 16)
      else $error("command fields overlap opcode bits");
  end

endmodule

// File: rtl/ind_reg_poll_ctr.sv
module ind_reg_poll_ctr #(
  parameter int MAX_POLLS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bump,
  output logic last
);

  localparam int CNT_W = $clog2(MAX_POLLS + 1);
  localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(MAX_POLLS - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (bump) cnt_q <= cnt_q + 1'b1;
  end

  assign last = (cnt_q == LAST_VAL);

  a_r3_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_VAL)
    else $error("poll counter past limit");

  a_r3_no_bump_at_last: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !clr) |-> !bump)
    else $error("poll retried after final attempt");

endmodule

// File: rtl/ind_reg_rsp_hold.sv
module ind_reg_rsp_hold
  import ind_reg_seq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  seq_status_e       load_status,
  input  logic [DATA_W-1:0] load_data,
  input  logic              rsp_valid,
  output logic [1:0]        rsp_err,
  output logic [DATA_W-1:0] rsp_rdata
);

  seq_status_e       status_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= ST_OK;
      data_q   <= '0;
    end else if (load) begin
      status_q <= load_status;
      data_q   <= (load_status == ST_OK) ? load_data : '0;
    end
  end

  assign rsp_err   = status_q;
  assign rsp_rdata = data_q;

  a_r9_data_zero_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err != 2'd0) |-> (rsp_rdata == '0))
    else $error("error response carries data");

endmodule

// File: rtl/ind_reg_seq.sv
module ind_reg_seq
  import ind_reg_seq_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int DEV_W     = 5,
  parameter int REG_W     = 5,
  parameter int DATA_W    = 16,
  parameter int MAX_POLLS = 16,
  parameter int BUSY_BIT  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] strap_addr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_start,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [REG_W-1:0]  bus_reg,
  output logic              bus_write,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_done,
  input  logic              bus_err,
  input  logic [DATA_W-1:0] bus_rdata
);

  localparam logic [REG_W-1:0] OFF_CMD  = REG_W'(0);
  localparam logic [REG_W-1:0] OFF_DATA = REG_W'(1);

  seq_phase_e        ph_q, ph_d;
  logic              launched_q, launched_d;
  logic              wr_q;
  logic [DEV_W-1:0]  dev_q;
  logic [REG_W-1:0]  reg_q;
  logic [DATA_W-1:0] wdata_q;

  logic              take_req;
  logic              in_tx;
  logic              tx_end;
  logic              poll_clr, poll_bump, poll_last;
  logic              fin;
  seq_status_e       fin_status;
  logic [DATA_W-1:0] fin_data;
  logic [DATA_W-1:0] cmd_word;
  logic              not_busy;

  ind_reg_cmd_fmt #(.DEV_W(DEV_W), .REG_W(REG_W), .DATA_W(DATA_W)) cmd_fmt_i (
    .is_write (wr_q),
    .dev_num  (dev_q),
    .reg_num  (reg_q),
    .cmd_word (cmd_word)
  );

  ind_reg_poll_ctr #(.MAX_POLLS(MAX_POLLS)) poll_ctr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (poll_clr),
    .bump  (poll_bump),
    .last  (poll_last)
  );

  ind_reg_rsp_hold #(.DATA_W(DATA_W)) rsp_hold_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (fin),
    .load_status (fin_status),
    .load_data   (fin_data),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .rsp_rdata   (rsp_rdata)
  );

  // handshake edges
  assign req_ready = (ph_q == PH_IDLE);
  assign rsp_valid = (ph_q == PH_RESP);
  assign take_req  = req_valid && req_ready;

  // bus port
  always_comb begin
    in_tx = (ph_q == PH_POLL_PRE) || (ph_q == PH_DATA_WR) || (ph_q == PH_CMD_WR) ||
            (ph_q == PH_POLL_POST) || (ph_q == PH_DATA_RD);
    bus_start = in_tx && !launched_q;
    bus_addr  = strap_addr;
    bus_write = (ph_q == PH_DATA_WR) || (ph_q == PH_CMD_WR);
    bus_reg   = ((ph_q == PH_DATA_WR) || (ph_q == PH_DATA_RD)) ? OFF_DATA : OFF_CMD;
    unique case (ph_q)
      PH_DATA_WR: bus_wdata = wdata_q;
      PH_CMD_WR:  bus_wdata = cmd_word;
      default:    bus_wdata = '0;
    endcase
  end

  assign tx_end   = launched_q && bus_done;
  assign not_busy = !bus_rdata[BUSY_BIT];

  // phase sequencing
  always_comb begin
    ph_d       = ph_q;
    launched_d = launched_q | bus_start;
    poll_clr   = 1'b0;
    poll_bump  = 1'b0;
    fin        = 1'b0;
    fin_status = ST_OK;
    fin_data   = '0;

    if (tx_end) begin
      launched_d = 1'b0;
      if (bus_err) begin
        fin        = 1'b1;
        fin_status = ST_BUSERR;
      end
    end

    unique case (ph_q)
      PH_IDLE: begin
        if (take_req) begin
          ph_d     = PH_POLL_PRE;
          poll_clr = 1'b1;
        end
      end
      PH_POLL_PRE: begin
        if (tx_end && !bus_err) begin
          if (not_busy)       ph_d = wr_q ? PH_DATA_WR : PH_CMD_WR;
          else if (poll_last) begin
            fin        = 1'b1;
            fin_status = ST_TIMEOUT;
          end else            poll_bump = 1'b1;
        end
      end
      PH_DATA_WR: begin
        if (tx_end && !bus_err) ph_d = PH_CMD_WR;
      end
      PH_CMD_WR: begin
        if (tx_end && !bus_err) begin
          ph_d     = PH_POLL_POST;
          poll_clr = 1'b1;
        end
      end
      PH_POLL_POST: begin
        if (tx_end && !bus_err) begin
          if (not_busy) begin
            if (wr_q) fin = 1'b1;
            else      ph_d = PH_DATA_RD;
          end else if (poll_last) begin
            fin        = 1'b1;
            fin_status = ST_TIMEOUT;
          end else poll_bump = 1'b1;
        end
      end
      PH_DATA_RD: begin
        if (tx_end && !bus_err) begin
          fin      = 1'b1;
          fin_data = bus_rdata;
        end
      end
      PH_RESP: begin
        if (rsp_ready) ph_d = PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase

    if (fin) begin
      ph_d       = PH_RESP;
      launched_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q       <= PH_IDLE;
      launched_q <= 1'b0;
    end else begin
      ph_q       <= ph_d;
      launched_q <= launched_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      dev_q   <= '0;
      reg_q   <= '0;
      wdata_q <= '0;
    end else if (take_req) begin
      wr_q    <= req_write;
      dev_q   <= req_dev;
      reg_q   <= req_reg;
      wdata_q <= req_wdata;
    end
  end

  a_r1_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!rsp_valid && !bus_start))
    else $error("ready while busy");

  a_r1_no_ready_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    take_req |=> !req_ready)
    else $error("ready right after acceptance");

  a_r10_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> !bus_start)
    else $error("second start before done");

  a_r7_abort_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_end && bus_err) |=> (rsp_valid && rsp_err == 2'd2 && !bus_start))
    else $error("sequence continued after bus error");

  a_r8_rsp_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_err) && $stable(rsp_rdata)))
    else $error("response changed while stalled");

endmodule

// File: tb/ind_reg_seq_tb_top.sv
module ind_reg_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  strap_addr = 5'd6;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [4:0]  req_dev = '0;
  logic [4:0]  req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [1:0]  rsp_err;
  logic [15:0] rsp_rdata;
  logic        bus_start;
  logic [4:0]  bus_addr;
  logic [4:0]  bus_reg;
  logic        bus_write;
  logic [15:0] bus_wdata;
  logic        bus_done = 1'b0;
  logic        bus_err = 1'b0;
  logic [15:0] bus_rdata = '0;

  always #10 clk = ~clk;

  ind_reg_seq dut_i (
    .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_dev(req_dev), .req_reg(req_reg), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .bus_start(bus_start), .bus_addr(bus_addr), .bus_reg(bus_reg), .bus_write(bus_write),
    .bus_wdata(bus_wdata), .bus_done(bus_done), .bus_err(bus_err), .bus_rdata(bus_rdata)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // bus model configuration and log
  int          busy_pre = 0, busy_post = 0, err_at = -1;
  logic [15:0] data_val = '0;
  int          n_tx = 0, cd = 0, seen_pre = 0, seen_post = 0;
  bit          cmd_written = 0;
  int          cur_idx = 0;
  logic [4:0]  lg_addr [0:63];
  logic [4:0]  lg_reg  [0:63];
  logic        lg_wr   [0:63];
  logic [15:0] lg_wd   [0:63];

  // expected list
  int          n_exp;
  logic [4:0]  ex_reg [0:63];
  logic        ex_wr  [0:63];
  logic [15:0] ex_wd  [0:63];
  int          ex_err;
  logic [15:0] ex_rdata;

  always @(negedge clk) begin
    if (bus_done) begin
      bus_done  = 1'b0;
      bus_err   = 1'b0;
      bus_rdata = '0;
    end
    if (cd > 0) begin
      cd = cd - 1;
      if (cd == 0) begin
        bus_done = 1'b1;
        if (cur_idx == err_at) bus_err = 1'b1;
        else if (lg_reg[cur_idx] == 5'd0 && !lg_wr[cur_idx]) begin
          if (!cmd_written) begin
            bus_rdata = (seen_pre < busy_pre) ? 16'hFFFF : 16'h7FFF;
            seen_pre++;
          end else begin
            bus_rdata = (seen_post < busy_post) ? 16'hFFFF : 16'h7FFF;
            seen_post++;
          end
        end else if (lg_reg[cur_idx] == 5'd0 && lg_wr[cur_idx]) cmd_written = 1;
        else if (!lg_wr[cur_idx]) bus_rdata = data_val;
      end
    end else if (bus_start) begin
      if (n_tx < 64) begin
        lg_addr[n_tx] = bus_addr;
        lg_reg[n_tx]  = bus_reg;
        lg_wr[n_tx]   = bus_write;
        lg_wd[n_tx]   = bus_wdata;
      end
      cur_idx = n_tx;
      n_tx++;
      cd = 2;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic add_exp(input logic wr, input logic [4:0] rg, input logic [15:0] wd);
    ex_reg[n_exp] = rg;
    ex_wr[n_exp]  = wr;
    ex_wd[n_exp]  = wd;
    n_exp++;
  endtask

  task automatic poll_exp(input int busy, output bit stop);
    bit ok = 0;
    stop = 0;
    for (int i = 0; i < 16; i++) begin
      add_exp(1'b0, 5'd0, 16'h0);
      if (n_exp - 1 == err_at) begin ex_err = 2; stop = 1; return; end
      if (i >= busy) begin ok = 1; break; end
    end
    if (!ok) begin ex_err = 1; stop = 1; end
  endtask

  task automatic build_exp(input logic wr, input logic [4:0] dev,
                           input logic [4:0] rg, input logic [15:0] wd);
    bit stop;
    logic [15:0] cmdw;
    cmdw = 16'h9000 | (wr ? 16'h0400 : 16'h0800) | (16'(dev) << 5) | 16'(rg);
    n_exp = 0; ex_err = 0; ex_rdata = 16'h0;
    poll_exp(busy_pre, stop);
    if (stop) return;
    if (wr) begin
      add_exp(1'b1, 5'd1, wd);
      if (n_exp - 1 == err_at) begin ex_err = 2; return; end
    end
    add_exp(1'b1, 5'd0, cmdw);
    if (n_exp - 1 == err_at) begin ex_err = 2; return; end
    poll_exp(busy_post, stop);
    if (stop) return;
    if (!wr) begin
      add_exp(1'b0, 5'd1, 16'h0);
      if (n_exp - 1 == err_at) begin ex_err = 2; return; end
      ex_rdata = data_val;
    end
  endtask

  task automatic run_case(input string req, input logic wr, input logic [4:0] dev,
                          input logic [4:0] rg, input logic [15:0] wd,
                          input int bpre, input int bpost, input int eat, input int hold);
    int wait_n;
    int bad;
    logic [1:0] e0;
    logic [15:0] d0;
    busy_pre = bpre; busy_post = bpost; err_at = eat;
    data_val = 16'h5A00 ^ {6'd0, dev, rg};
    n_tx = 0; seen_pre = 0; seen_post = 0; cmd_written = 0;
    build_exp(wr, dev, rg, wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_dev = dev; req_reg = rg; req_wdata = wd;
    wait_n = 0;
    while (!req_ready && wait_n < 1000) begin @(negedge clk); wait_n++; end
    @(negedge clk);
    // R1: garbage held on the request port while busy must be ignored
    chk(req_ready == 1'b0, "R1", {req, " ready low while busy"}, req_ready, 0);
    req_write = ~wr; req_dev = ~dev; req_reg = ~rg; req_wdata = ~wd;
    wait_n = 0;
    while (!rsp_valid && wait_n < 2000) begin @(negedge clk); wait_n++; end
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, "R8", {req, " response arrives"}, rsp_valid, 1);
    e0 = rsp_err; d0 = rsp_rdata;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_err == e0 && rsp_rdata == d0, "R8",
          {req, " response held"}, rsp_rdata, d0);
    end
    chk(rsp_err == 2'(ex_err), req, "status", rsp_err, ex_err);
    chk(rsp_rdata == ex_rdata, (ex_err == 0 && !wr) ? "R4" : "R9", {req, " rdata"},
        rsp_rdata, ex_rdata);
    bad = -1;
    for (int i = 0; i < n_exp && i < n_tx; i++)
      if (bad < 0 && (lg_reg[i] != ex_reg[i] || lg_wr[i] != ex_wr[i] ||
          (ex_wr[i] && lg_wd[i] != ex_wd[i]) || lg_addr[i] != strap_addr)) bad = i;
    chk(n_tx == n_exp, req, "transaction count", n_tx, n_exp);
    chk(bad < 0, req, "transaction order (R10 address)",
        bad < 0 ? 0 : {lg_wr[bad], lg_reg[bad], lg_wd[bad]},
        bad < 0 ? 0 : {ex_wr[bad], ex_reg[bad], ex_wd[bad]});
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R8", {req, " single response"}, rsp_valid, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk(req_ready == 1 && rsp_valid == 0 && bus_start == 0, "R1", "reset state",
        {req_ready, rsp_valid, bus_start}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1 && rsp_valid == 0 && bus_start == 0, "R1", "idle after reset",
        {req_ready, rsp_valid, bus_start}, 3'b100);

    // R2 R3: busy sweep on the first wait phase
    for (int a = 0; a <= 17; a++) begin
      run_case(a >= 16 ? "R3" : "R2", 1'b0, 5'd3, 5'd9, 16'h0, a, 0, -1, 0);
      run_case(a >= 16 ? "R3" : "R2", 1'b1, 5'd3, 5'd9, 16'hC0DE, a, 0, -1, 0);
    end
    // R4 R5: busy sweep on the second wait phase
    for (int b = 0; b <= 17; b++) begin
      run_case(b >= 16 ? "R3" : "R4", 1'b0, 5'd17, 5'd2, 16'h0, 1, b, -1, 0);
      run_case(b >= 16 ? "R3" : "R5", 1'b1, 5'd17, 5'd2, 16'hBEEF, 1, b, -1, 0);
    end
    // R7: bus error at every position
    for (int e = 0; e <= 5; e++) begin
      run_case("R7", 1'b0, 5'd8, 5'd30, 16'h0, 1, 1, e, 0);
      run_case("R7", 1'b1, 5'd8, 5'd30, 16'h1234, 1, 1, e, 0);
    end
    // R6: command word over device/register corners
    for (int d = 0; d < 3; d++)
      for (int r = 0; r < 3; r++) begin
        run_case("R6", 1'b0, d == 0 ? 5'd0 : (d == 1 ? 5'd21 : 5'd31),
                 r == 0 ? 5'd0 : (r == 1 ? 5'd10 : 5'd31), 16'h0, 0, 0, -1, 0);
        run_case("R6", 1'b1, d == 0 ? 5'd0 : (d == 1 ? 5'd21 : 5'd31),
                 r == 0 ? 5'd0 : (r == 1 ? 5'd10 : 5'd31), 16'hA55A, 0, 0, -1, 0);
      end
    // R8: stalled responses
    run_case("R8", 1'b0, 5'd5, 5'd5, 16'h0, 2, 3, -1, 4);
    run_case("R8", 1'b1, 5'd5, 5'd5, 16'h7777, 0, 0, 2, 3);
    strap_addr = 5'd30;
    run_case("R10", 1'b0, 5'd1, 5'd1, 16'h0, 1, 1, -1, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule